// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Core

This block is a small processor core that completes one instruction in every clock cycle. On each rising edge it commits the effects of the instruction at the current program counter: it fetches the word from an internal instruction store, decodes it, reads two source registers, computes an ALU result or address, optionally reads or writes an internal data store, writes one register and moves the program counter. The supported subset is word load, word store, add, subtract, bitwise and, bitwise or, signed set-less-than, branch-if-equal and unconditional jump.

Both stores are small word arrays inside the core. They are filled through a preload port while the core is held in reset. The register write-back and the data-store write of the instruction in flight are visible on output ports, so a surrounding test or debug harness can follow execution.

Top module: `scc_core`

## Requirements
- R1: A synchronous active-low reset sets the program counter to 0x00400000 on the next rising edge; while reset is held the counter stays there and the data store is not written by instructions.
- R2: Apart from a taken branch or a jump, the program counter increases by 4 on every rising edge. Instruction word index is taken from PC bits above bit 1.
- R3: BEQ (opcode 0x04, rs in bits 25:21, rt in bits 20:16, offset in bits 15:0) loads the program counter with PC+4 plus the sign-extended offset shifted left by two when the two registers are equal, and with PC+4 otherwise; negative offsets branch backwards.
- R4: J (opcode 0x02) loads the program counter with bits 31:28 of PC+4, followed by instruction bits 25:0, followed by two zero bits.
- R5: R-type instructions (opcode 0x00, function in bits 5:0: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than giving 1 or 0) write the result of rs op rt to register rd (bits 15:11).
- R6: LW (opcode 0x23) reads the data-store word at rs plus the sign-extended 16-bit offset and writes it to register rt.
- R7: SW (opcode 0x2B) writes register rt to the data-store word at rs plus the sign-extended offset on the rising edge, and writes no register; a later LW of that address returns the stored value.
- R8: Register 0 always reads as zero; writes that target it have no effect.
- R9: An instruction whose destination is also a source reads the old value and the new value appears from the next instruction on.
- R10: BEQ and J write neither a register nor the data store; R-type and LW write a register and never the data store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Preload strobe, one word per rising edge |
| load_dmem | input | 1 | Preload target: 0 instruction store, 1 data store |
| load_addr | input | 6 | Preload word index |
| load_data | input | 32 | Preload word |
| pc_o | output | 32 | Program counter of the instruction in flight |
| wb_en | output | 1 | Instruction in flight writes a register |
| wb_addr | output | 5 | Destination register number |
| wb_data | output | 32 | Value written to the destination register |
| dmem_we | output | 1 | Instruction in flight writes the data store |
| dmem_addr | output | 32 | Byte address computed by the ALU |
| dmem_wdata | output | 32 | Word written to the data store |

## Verification
The write-back and store outputs belong to the instruction in flight and settle combinationally within the cycle its program counter is shown, while the program counter changes one rising edge later. The bench therefore samples every output at the falling edge, compares it with an instruction-level model stepped once per cycle, and only then advances the model, so each result is compared in the very cycle it becomes due. The reset value is compared at a falling edge after a rising edge with reset low.

// File: rtl/scc_pkg.sv
// Shared encodings and control types for the single-cycle core.
// Assumes the fixed 32-bit instruction layout with opcode in bits 31:26.
package scc_pkg;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_JUMP  = 6'h02;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    // Class of ALU use chosen by the main decoder.
    typedef enum logic [1:0] {
        AC_MEM = 2'b00,
        AC_CMP = 2'b01,
        AC_REG = 2'b10
    } alu_class_e;

    // Operation actually performed by the ALU.
    typedef enum logic [2:0] {
        AF_ADD = 3'd0,
        AF_SUB = 3'd1,
        AF_AND = 3'd2,
        AF_OR  = 3'd3,
        AF_SLT = 3'd4
    } alu_fn_e;

    typedef struct packed {
        logic       dst_is_rd;
        logic       opb_is_imm;
        logic       wb_from_mem;
        logic       reg_write;
        logic       mem_read;
        logic       mem_write;
        logic       branch;
        logic       jump;
        alu_class_e alu_class;
    } ctl_t;

endpackage

// File: rtl/scc_control.sv
// Instruction decoder: maps opcode to datapath controls and opcode plus
// function field to an ALU operation. Purely combinational; unknown
// opcodes decode to an instruction with no side effects.
module scc_control
    import scc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctl_t       ctl,
    output alu_fn_e    alu_fn
);

    // Main decode: one control word per instruction class.
    always_comb begin
        ctl           = '0;
        ctl.alu_class = AC_MEM;
        case (opcode)
            OP_RTYPE: begin
                ctl.dst_is_rd = 1'b1;
                ctl.reg_write = 1'b1;
                ctl.alu_class = AC_REG;
            end
            OP_LOAD: begin
                ctl.opb_is_imm  = 1'b1;
                ctl.wb_from_mem = 1'b1;
                ctl.reg_write   = 1'b1;
                ctl.mem_read    = 1'b1;
            end
            OP_STORE: begin
                ctl.opb_is_imm = 1'b1;
                ctl.mem_write  = 1'b1;
            end
            OP_BEQ: begin
                ctl.branch    = 1'b1;
                ctl.alu_class = AC_CMP;
            end
            OP_JUMP: begin
                ctl.jump = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

    // Second-level decode: ALU operation from class and function field.
    always_comb begin
        case (ctl.alu_class)
            AC_MEM: alu_fn = AF_ADD;
            AC_CMP: alu_fn = AF_SUB;
            AC_REG: begin
                case (funct)
                    FN_ADD:  alu_fn = AF_ADD;
                    FN_SUB:  alu_fn = AF_SUB;
                    FN_AND:  alu_fn = AF_AND;
                    FN_OR:   alu_fn = AF_OR;
                    FN_SLT:  alu_fn = AF_SLT;
                    default: alu_fn = AF_ADD;
                endcase
            end
            default: alu_fn = AF_ADD;
        endcase
    end

endmodule

// File: rtl/scc_regfile.sv
// General register file: two combinational read ports, one write port
// taken on the rising clock edge. Entry 0 is never written and reads zero.
// Assumes a synchronous active-low reset that clears every entry.
module scc_regfile #(
    parameter int AW    = 5,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ra_a,
    input  logic [AW-1:0]    ra_b,
    output logic [WIDTH-1:0] rd_a,
    output logic [WIDTH-1:0] rd_b,
    input  logic             we,
    input  logic [AW-1:0]    wa,
    input  logic [WIDTH-1:0] wd
);

    localparam int NREGS = 1 << AW;

    logic [WIDTH-1:0] regs [NREGS];

    // Edge-triggered update; writes to entry 0 are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    // Read ports return the stored value directly.
    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];

    // R8: entry 0 keeps reading zero whatever has been written.
    a_r8_zero_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_a == '0) |-> (rd_a == '0));

    // R9: a committed write is held by the addressed entry afterwards.
    a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (wa != '0)) |=> (regs[$past(wa)] == $past(wd)));

endmodule

// File: rtl/scc_alu.sv
// Integer ALU: add, subtract, and, or and signed set-less-than, with a
// zero flag used for equality branches. Combinational.
module scc_alu
    import scc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_fn_e          fn,
    output logic [WIDTH-1:0] y,
    output logic             zero
);

    // Operation select.
    always_comb begin
        case (fn)
            AF_ADD:  y = a + b;
            AF_SUB:  y = a - b;
            AF_AND:  y = a & b;
            AF_OR:   y = a | b;
            AF_SLT:  y = {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    // Zero flag for the branch comparison.
    assign zero = (y == '0);

endmodule

// File: rtl/scc_core.sv
// Single-cycle core top: program counter, instruction and data stores,
// decoder, register file, ALU, branch and jump target logic and the
// datapath selects. Stores are filled through the preload port while
// rst_n is low. Assumes word-aligned accesses; address bits 1:0 ignored.
module scc_core
    import scc_pkg::*;
#(
    parameter int          IMEM_AW  = 6,
    parameter int          DMEM_AW  = 6,
    parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          load_en,
    input  logic                                          load_dmem,
    input  logic [((IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW)-1:0] load_addr,
    input  logic [31:0]                                   load_data,
    output logic [31:0]                                   pc_o,
    output logic                                          wb_en,
    output logic [4:0]                                    wb_addr,
    output logic [31:0]                                   wb_data,
    output logic                                          dmem_we,
    output logic [31:0]                                   dmem_addr,
    output logic [31:0]                                   dmem_wdata
);

    localparam int IMEM_WORDS = 1 << IMEM_AW;
    localparam int DMEM_WORDS = 1 << DMEM_AW;

    logic [31:0] imem [IMEM_WORDS];
    logic [31:0] dmem [DMEM_WORDS];

    logic [31:0] pc_q;
    logic [31:0] pc_next;
    logic [31:0] pc_plus4;
    logic [31:0] br_target;
    logic [31:0] jmp_target;
    logic [31:0] instr;
    logic [31:0] imm_ext;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic [31:0] alu_b;
    logic [31:0] alu_y;
    logic        alu_zero;
    logic [31:0] mem_rdata;
    logic [4:0]  dst_reg;
    logic [31:0] wb_value;
    logic        take_branch;
    ctl_t        ctl;
    alu_fn_e     alu_fn;

    // Instruction store preload.
    always_ff @(posedge clk) begin
        if (load_en && !load_dmem) imem[load_addr[IMEM_AW-1:0]] <= load_data;
    end

    // Data store: preload, or store instruction outside reset.
    always_ff @(posedge clk) begin
        if (load_en && load_dmem)
            dmem[load_addr[DMEM_AW-1:0]] <= load_data;
        else if (rst_n && ctl.mem_write)
            dmem[alu_y[DMEM_AW+1:2]] <= rt_val;
    end

    // Program counter: written every edge, no enable.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= pc_next;
    end

    // Fetch and immediate sign extension.
    assign instr   = imem[pc_q[IMEM_AW+1:2]];
    assign imm_ext = {{16{instr[15]}}, instr[15:0]};

    scc_control u_control (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctl    (ctl),
        .alu_fn (alu_fn)
    );

    // Destination select: rd for register ops, rt for loads.
    assign dst_reg = ctl.dst_is_rd ? instr[15:11] : instr[20:16];

    scc_regfile #(.AW(5), .WIDTH(32)) u_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (instr[25:21]),
        .ra_b  (instr[20:16]),
        .rd_a  (rs_val),
        .rd_b  (rt_val),
        .we    (ctl.reg_write),
        .wa    (dst_reg),
        .wd    (wb_value)
    );

    // Second operand select: register or sign-extended offset.
    assign alu_b = ctl.opb_is_imm ? imm_ext : rt_val;

    scc_alu #(.WIDTH(32)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .fn   (alu_fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Combinational data read and write-back select.
    assign mem_rdata = ctl.mem_read ? dmem[alu_y[DMEM_AW+1:2]] : '0;
    assign wb_value  = ctl.wb_from_mem ? mem_rdata : alu_y;

    // Next-PC: separate incrementer and branch adder, jump concatenation.
    assign pc_plus4    = pc_q + 32'd4;
    assign br_target   = pc_plus4 + {imm_ext[29:0], 2'b00};
    assign jmp_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
    assign take_branch = ctl.branch && alu_zero;

    always_comb begin
        if (ctl.jump)         pc_next = jmp_target;
        else if (take_branch) pc_next = br_target;
        else                  pc_next = pc_plus4;
    end

    // Observation outputs for the instruction in flight.
    assign pc_o       = pc_q;
    assign wb_en      = ctl.reg_write;
    assign wb_addr    = dst_reg;
    assign wb_data    = wb_value;
    assign dmem_we    = ctl.mem_write;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;

    // R2: without branch or jump the counter steps by one word.
    a_r2_sequential_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.branch && !ctl.jump) |=> (pc_q == $past(pc_q) + 32'd4));

    // R3: equal operands on a branch redirect to the offset target.
    a_r3_branch_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.branch && (rs_val == rt_val)) |=>
        (pc_q == $past(pc_q) + 32'd4 + {$past(imm_ext[29:0]), 2'b00}));

    // R4: jump target built from upper PC bits and the index field.
    a_r4_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.jump |=> (pc_q[27:0] == {$past(instr[25:0]), 2'b00}));

    // R7: a store never writes a register.
    a_r7_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> !wb_en);

    // R10: branch and jump leave registers and data store alone.
    a_r10_ctrl_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((instr[31:26] == OP_BEQ) || (instr[31:26] == OP_JUMP)) |-> (!wb_en && !dmem_we));

endmodule

// File: tb/scc_core_bench.sv
// Bench: preloads a program and data, then steps an instruction-level
// model once per cycle and compares every output at the falling edge.
`timescale 1ns/1ps
module scc_core_bench;

    localparam logic [31:0] BASE = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic        load_dmem = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [31:0] pc_o;
    logic        wb_en;
    logic [4:0]  wb_addr;
    logic [31:0] wb_data;
    logic        dmem_we;
    logic [31:0] dmem_addr;
    logic [31:0] dmem_wdata;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] prog   [64];
    logic [31:0] m_dmem [64];
    logic [31:0] m_reg  [32];
    logic [31:0] m_pc;

    always #2 clk = ~clk;

    scc_core u_scc_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .load_dmem  (load_dmem),
        .load_addr  (load_addr),
        .load_data  (load_data),
        .pc_o       (pc_o),
        .wb_en      (wb_en),
        .wb_addr    (wb_addr),
        .wb_data    (wb_data),
        .dmem_we    (dmem_we),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rt_op(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] it_op(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] j_op(input int idx);
        logic [31:0] a;
        a = BASE + 32'(idx * 4);
        return {6'h02, a[27:2]};
    endfunction

    // Watchdog: counts as a failed check and still reports.
    initial begin
        #(4 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL R2 watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // Program and data image.
        for (int i = 0; i < 64; i++) begin
            prog[i]   = 32'h0;
            m_dmem[i] = 32'(i * 3);
        end
        m_dmem[0] = 32'd5;
        m_dmem[1] = 32'hFFFF_FFFD;
        prog[0]  = it_op(6'h23, 0, 1, 16'd0);
        prog[1]  = it_op(6'h23, 0, 2, 16'd4);
        prog[2]  = rt_op(1, 2, 3, 6'h20);
        prog[3]  = rt_op(1, 2, 4, 6'h22);
        prog[4]  = rt_op(1, 2, 5, 6'h24);
        prog[5]  = rt_op(1, 2, 6, 6'h25);
        prog[6]  = rt_op(2, 1, 7, 6'h2A);
        prog[7]  = rt_op(1, 2, 8, 6'h2A);
        prog[8]  = rt_op(1, 1, 1, 6'h20);
        prog[9]  = rt_op(1, 1, 0, 6'h20);
        prog[10] = rt_op(0, 1, 9, 6'h20);
        prog[11] = it_op(6'h2B, 0, 9, 16'd8);
        prog[12] = it_op(6'h23, 4, 10, 16'hFFFC);
        prog[13] = it_op(6'h2B, 9, 3, 16'hFFFE);
        prog[14] = it_op(6'h23, 0, 11, 16'd8);
        prog[15] = it_op(6'h04, 1, 2, 16'd5);
        prog[16] = it_op(6'h04, 3, 11, 16'd2);
        prog[17] = rt_op(1, 1, 12, 6'h20);
        prog[18] = rt_op(1, 1, 12, 6'h20);
        prog[19] = j_op(22);
        prog[20] = rt_op(1, 1, 12, 6'h20);
        prog[21] = rt_op(1, 1, 12, 6'h20);
        prog[22] = rt_op(11, 4, 12, 6'h22);
        prog[23] = it_op(6'h04, 0, 0, 16'd2);
        prog[24] = rt_op(1, 1, 12, 6'h20);
        prog[25] = rt_op(1, 1, 12, 6'h20);
        prog[26] = rt_op(12, 0, 13, 6'h2A);
        prog[27] = rt_op(0, 13, 14, 6'h22);
        prog[28] = it_op(6'h04, 0, 0, 16'hFFFF);
        for (int i = 0; i < 32; i++) m_reg[i] = '0;

        // Preload both stores while reset is held.
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            load_en   = 1'b1;
            load_dmem = (i >= 64);
            load_addr = 6'(i % 64);
            load_data = (i >= 64) ? m_dmem[i - 64] : prog[i];
        end
        @(negedge clk);
        load_en = 1'b0;
        @(negedge clk);
        #0.5;
        check("R1 reset pc", pc_o, BASE);
        check("R10 no store in reset state", {31'd0, dmem_we}, 32'd0);

        m_pc  = BASE;
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 40; cyc++) begin
            logic [31:0] ins;
            logic [5:0]  op;
            int          rs, rt, rd;
            logic [31:0] sx, ea, res, npc;
            string       t;
            #0.5;
            ins = prog[m_pc[7:2]];
            op  = ins[31:26];
            rs  = int'(ins[25:21]);
            rt  = int'(ins[20:16]);
            rd  = int'(ins[15:11]);
            sx  = {{16{ins[15]}}, ins[15:0]};
            ea  = m_reg[rs] + sx;
            npc = m_pc + 32'd4;
            if (op == 6'h00) begin
                case (ins[5:0])
                    6'h20:   res = m_reg[rs] + m_reg[rt];
                    6'h22:   res = m_reg[rs] - m_reg[rt];
                    6'h24:   res = m_reg[rs] & m_reg[rt];
                    6'h25:   res = m_reg[rs] | m_reg[rt];
                    default: res = ($signed(m_reg[rs]) < $signed(m_reg[rt])) ? 32'd1 : 32'd0;
                endcase
                t = (rd == 0) ? "R8 write to r0" :
                    ((rd == rs || rd == rt) ? "R9 src equals dst" :
                    ((rs == 0) ? "R8 r0 source" : "R5 register op"));
                check({t, " wb_en"}, {31'd0, wb_en}, 32'd1);
                check({t, " wb_addr"}, {27'd0, wb_addr}, 32'(rd));
                check({t, " wb_data"}, wb_data, res);
                check("R10 reg op no store", {31'd0, dmem_we}, 32'd0);
                if (rd != 0) m_reg[rd] = res;
                check("R2 pc", pc_o, m_pc);
            end else if (op == 6'h23) begin
                res = m_dmem[ea[7:2]];
                check("R6 load wb_en", {31'd0, wb_en}, 32'd1);
                check("R6 load wb_addr", {27'd0, wb_addr}, 32'(rt));
                check("R6 load wb_data", wb_data, res);
                check("R10 load no store", {31'd0, dmem_we}, 32'd0);
                if (rt != 0) m_reg[rt] = res;
                check("R2 pc", pc_o, m_pc);
            end else if (op == 6'h2B) begin
                check("R7 store we", {31'd0, dmem_we}, 32'd1);
                check("R7 store addr", dmem_addr, ea);
                check("R7 store data", dmem_wdata, m_reg[rt]);
                check("R7 store no wb", {31'd0, wb_en}, 32'd0);
                m_dmem[ea[7:2]] = m_reg[rt];
                check("R2 pc", pc_o, m_pc);
            end else if (op == 6'h04) begin
                check("R10 branch no wb", {31'd0, wb_en}, 32'd0);
                check("R10 branch no store", {31'd0, dmem_we}, 32'd0);
                check("R3 pc", pc_o, m_pc);
                if (m_reg[rs] == m_reg[rt]) npc = npc + {sx[29:0], 2'b00};
            end else begin
                check("R10 jump no wb", {31'd0, wb_en}, 32'd0);
                check("R4 pc", pc_o, m_pc);
                npc = {npc[31:28], ins[25:0], 2'b00};
            end
            m_pc = npc;
            @(negedge clk);
        end

        // Reset again mid-run.
        rst_n = 1'b0;
        @(negedge clk);
        #0.5;
        check("R1 reset pc again", pc_o, BASE);
        @(negedge clk);
        #0.5;
        check("R1 pc held in reset", pc_o, BASE);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule